// File: doc/BRIEF.md
# Hot-Plug Slot Fault Supervisor

This block watches the digital health flags of one hot-plug slot and decides when to raise the slot's fault indication and when to report that power is good. The flags come from analog comparators and breakers outside the block. They are the two slot enable requests (main and auxiliary), undervoltage flags for the 12 V, 3.3 V and standby rails, fast and slow overcurrent trips, a slot over-temperature flag and a global over-temperature flag. The block passes every flag through a multi-stage synchronizer. The slow overcurrent trip only counts as a fault after a programmable filter time has run out, or at once if the slot is also too hot.

A fault can only be raised while the slot is requested on. Once raised, it stays latched until software or the system withdraws both enable requests. A diagnostic force-on input, active low, turns off all protection and returns both status outputs to their inactive level. A control-register inhibit bit can disable that input. Both outputs are registered and active low, and they stay inactive during reset.

Top module: `hp_slot_supervisor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with all inputs idle, `fault_n` and `pgood_n` are both 1 (inactive).
- R2: `fault_n` goes low only while at least one of `en_main`/`en_aux` is 1. With both enables 0, no combination of trip flags lowers `fault_n`.
- R3: With the slot enabled and force-on not active, a 1 on any of `uv_12`, `uv_3v3`, `uv_stby` lowers `fault_n`. The delay is SYNC_STAGES+1 rising edges after the pin changes, which is 3 edges with SYNC_STAGES=2.
- R4: With the slot enabled, a 1 on `oc_fast` lowers `fault_n` after the same SYNC_STAGES+1 edges.
- R5: With the slot enabled, `oc_slow` alone lowers `fault_n` only after it has been 1 without a break for FILT_CYCLES further edges, so the total is SYNC_STAGES+1+FILT_CYCLES edges. A pulse shorter than that raises no fault, and the filter count restarts from zero whenever `oc_slow` returns to 0.
- R6: With the slot enabled, `oc_slow` together with `ot_slot` lowers `fault_n` without waiting for the filter. `ot_slot` alone raises no fault.
- R7: With the slot enabled, `ot_global` lowers `fault_n` after SYNC_STAGES+1 edges.
- R8: Once `fault_n` is low, it stays low after every trip flag returns to 0 and while either enable is still 1. It returns to 1 SYNC_STAGES+1 edges after both enables reach 0.
- R9: Force-on is active when `force_on_n`=0 and `force_inhibit`=0. While it is active, `fault_n`=1 and `pgood_n`=1 whatever the trip flags, and any latched fault is cleared.
- R10: With `force_inhibit`=1, `force_on_n` has no effect: trips latch a fault and `pgood_n` follows R11.
- R11: `pgood_n` is 0 exactly when the slot is enabled, force-on is not active, no undervoltage flag is 1 and no fault is latched (or latching). It uses the same SYNC_STAGES+1 edge delay as `fault_n`, so the two outputs are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_main | input | 1 | Main slot enable request |
| en_aux | input | 1 | Auxiliary slot enable request |
| uv_12 | input | 1 | 12 V rail undervoltage flag |
| uv_3v3 | input | 1 | 3.3 V rail undervoltage flag |
| uv_stby | input | 1 | Standby rail undervoltage flag |
| oc_fast | input | 1 | Fast overcurrent breaker tripped |
| oc_slow | input | 1 | Slow overcurrent breaker tripped |
| ot_slot | input | 1 | Slot die temperature above its limit |
| ot_global | input | 1 | Global die temperature above its limit |
| force_on_n | input | 1 | Diagnostic force-on request, active low |
| force_inhibit | input | 1 | Control bit; 1 disables force-on |
| fault_n | output | 1 | Latched slot fault, active low |
| pgood_n | output | 1 | Slot power good, active low |

## Verification
The hardest case to reach is the slow overcurrent path. Its fault depends on how long the trip has been held, and that history cannot be seen at the ports. The bench sets FILT_CYCLES small, holds `oc_slow` alone and samples the edge just before and just after the filter runs out. It then sends a pulse one edge short of the limit, drops it, and sends another short pulse, which shows that the count restarts at zero. Latch retention and release are reached by raising a fast trip, removing it, and then withdrawing the two enables one at a time.

// File: rtl/hps_pkg.sv
package hps_pkg;

   typedef struct packed {
      logic en_main;
      logic en_aux;
      logic uv_12;
      logic uv_3v3;
      logic uv_stby;
      logic oc_fast;
      logic oc_slow;
      logic ot_slot;
      logic ot_global;
      logic force_n;
   } hps_flags_t;

   localparam int FLAG_W = $bits(hps_flags_t);

   // Level every synchronizer stage holds in reset: all flags quiet,
   // force request released (active low).
   localparam hps_flags_t FLAGS_IDLE = '{force_n: 1'b1, default: 1'b0};

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hps_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hps_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hps_slow_filter.sv
module hps_slow_filter #(
   parameter int  CYCLES = 16,
   localparam int CW     = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trip,
   output logic          expired,
   output logic [CW-1:0] count
);

   generate
      if (CYCLES < 0) begin : g_bad_cycles
         $error("hps_slow_filter: CYCLES must not be negative");
      end

      if (CYCLES == 0) begin : g_no_filter
         assign count   = '0;
         assign expired = trip;
      end else begin : g_counter
         localparam logic [CW-1:0] LIMIT = CW'(CYCLES);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (!trip)        cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end

         assign count   = cnt_q;
         assign expired = trip && (cnt_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/hps_fault_core.sv
module hps_fault_core
   import hps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  hps_flags_t flg,
   input  logic       slow_expired,
   input  logic       force_inhibit,
   output logic       en_any,
   output logic       force_act,
   output logic       fault_q,
   output logic       pgood_q
);

   logic uv_any;
   logic trip_now;
   logic fault_d;

   always_comb begin
      en_any    = flg.en_main | flg.en_aux;
      force_act = ~flg.force_n & ~force_inhibit;
      uv_any    = flg.uv_12 | flg.uv_3v3 | flg.uv_stby;
      trip_now  = uv_any
                | flg.oc_fast
                | (flg.oc_slow & slow_expired)
                | (flg.oc_slow & flg.ot_slot)
                | flg.ot_global;
      fault_d   = en_any & ~force_act & (fault_q | trip_now);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         pgood_q <= 1'b0;
      end else begin
         fault_q <= fault_d;
         pgood_q <= en_any & ~force_act & ~uv_any & ~fault_d;
      end
   end

endmodule

// File: rtl/hp_slot_supervisor.sv
module hp_slot_supervisor
   import hps_pkg::*;
#(
   parameter int  SYNC_STAGES = 2,
   parameter int  FILT_CYCLES = 64,
   localparam int CW          = (FILT_CYCLES < 1) ? 1 : $clog2(FILT_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_main,
   input  logic en_aux,
   input  logic uv_12,
   input  logic uv_3v3,
   input  logic uv_stby,
   input  logic oc_fast,
   input  logic oc_slow,
   input  logic ot_slot,
   input  logic ot_global,
   input  logic force_on_n,
   input  logic force_inhibit,
   output logic fault_n,
   output logic pgood_n
);

   hps_flags_t flg_raw;
   hps_flags_t flg_s;
   logic       slow_expired;
   logic [CW-1:0] flt_cnt;
   logic       en_any;
   logic       force_act;
   logic       fault_q;
   logic       pgood_q;

   always_comb begin
      flg_raw.en_main   = en_main;
      flg_raw.en_aux    = en_aux;
      flg_raw.uv_12     = uv_12;
      flg_raw.uv_3v3    = uv_3v3;
      flg_raw.uv_stby   = uv_stby;
      flg_raw.oc_fast   = oc_fast;
      flg_raw.oc_slow   = oc_slow;
      flg_raw.ot_slot   = ot_slot;
      flg_raw.ot_global = ot_global;
      flg_raw.force_n   = force_on_n;
   end

   hps_sync #(
      .W       (FLAG_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (FLAGS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flg_raw),
      .q     (flg_s)
   );

   hps_slow_filter #(
      .CYCLES (FILT_CYCLES)
   ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip    (flg_s.oc_slow),
      .expired (slow_expired),
      .count   (flt_cnt)
   );

   hps_fault_core u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .flg           (flg_s),
      .slow_expired  (slow_expired),
      .force_inhibit (force_inhibit),
      .en_any        (en_any),
      .force_act     (force_act),
      .fault_q       (fault_q),
      .pgood_q       (pgood_q)
   );

   assign fault_n = ~fault_q;
   assign pgood_n = ~pgood_q;

endmodule

// File: rtl/hps_sup_chk.sv
module hps_sup_chk #(
   parameter int CW = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fault_n,
   input logic          pgood_n,
   input logic          en_any,
   input logic          force_act,
   input logic          oc_fast_s,
   input logic          oc_slow_s,
   input logic [CW-1:0] flt_cnt
);

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_idle_chk: assert (fault_n && pgood_n);
      end
   end

   // R2
   fault_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> $past(en_any));

   // R4
   fast_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_any && !force_act && oc_fast_s) |=> !fault_n);

   // R5
   filter_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oc_slow_s |=> (flt_cnt == '0));

   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && en_any && !force_act) |=> !fault_n);

   // R9
   force_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_act |=> (fault_n && pgood_n));

   // R11
   outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fault_n && !pgood_n));

endmodule

bind hp_slot_supervisor hps_sup_chk #(.CW(CW)) u_sup_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fault_n   (fault_n),
   .pgood_n   (pgood_n),
   .en_any    (en_any),
   .force_act (force_act),
   .oc_fast_s (flg_s.oc_fast),
   .oc_slow_s (flg_s.oc_slow),
   .flt_cnt   (flt_cnt)
);

// File: tb/test_hp_slot_supervisor.sv
`timescale 1ns/1ps
module test_hp_slot_supervisor;

   localparam int S   = 2;
   localparam int T   = 6;
   localparam int LAT = S + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_main = 0, en_aux = 0, uv_12 = 0, uv_3v3 = 0, uv_stby = 0;
   logic oc_fast = 0, oc_slow = 0, ot_slot = 0, ot_global = 0;
   logic force_on_n = 1, force_inhibit = 0;
   logic fault_n, pgood_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   hp_slot_supervisor #(.SYNC_STAGES(S), .FILT_CYCLES(T)) i_hp_slot_supervisor (
      .clk, .rst_n, .en_main, .en_aux, .uv_12, .uv_3v3, .uv_stby,
      .oc_fast, .oc_slow, .ot_slot, .ot_global, .force_on_n, .force_inhibit,
      .fault_n, .pgood_n
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act_f, input logic exp_f,
                      input logic act_p, input logic exp_p);
      n_chk++;
      if (act_f !== exp_f || act_p !== exp_p) begin
         n_bad++;
         $display("FAIL %s: fault_n=%b pgood_n=%b expected fault_n=%b pgood_n=%b at %0t",
                  req, act_f, act_p, exp_f, exp_p, $time);
      end
   endtask

   task automatic idle();
      {en_main, en_aux, uv_12, uv_3v3, uv_stby, oc_fast, oc_slow, ot_slot, ot_global} = '0;
      force_on_n = 1; force_inhibit = 0;
   endtask

   initial begin
      idle();
      step(3);
      // R1: reset holds both outputs inactive
      chk("R1", fault_n, 1, pgood_n, 1);
      rst_n = 1;
      step(1);
      chk("R1", fault_n, 1, pgood_n, 1);

      // R2 R3 R4 R6 R7 R11: sweep of enables and static trip flags
      for (int v = 0; v < 1024; v++) begin
         logic em, ea, u1, u2, u3, ff, sl, os, og;
         logic en, exp_fault;
         idle();
         step(LAT + 1);
         chk("R8", fault_n, 1, pgood_n, 1);
         {em, ea, u1, u2, u3, ff, sl, os, og} = v[8:0];
         en_main = em; en_aux = ea; uv_12 = u1; uv_3v3 = u2; uv_stby = u3;
         oc_fast = ff; oc_slow = sl; ot_slot = os; ot_global = og;
         force_on_n = v[9] ? 1'b1 : 1'b0;
         force_inhibit = 1'b1;   // R10: force_on_n toggled but inhibited
         step(LAT);
         en = em | ea;
         exp_fault = en & (u1 | u2 | u3 | ff | (sl & os) | og);
         // R2 R3 R4 R6 R7 R10 R11
         chk("R2/R3/R4/R6/R7/R10/R11 sweep", fault_n, ~exp_fault,
             pgood_n, ~(en & ~exp_fault));
      end

      // R5: slow trip alone, filter boundary
      idle(); step(LAT + 1);
      en_main = 1; step(LAT);
      chk("R11 enabled", fault_n, 1, pgood_n, 0);
      oc_slow = 1;
      step(LAT + T - 1);
      chk("R5 before expiry", fault_n, 1, pgood_n, 0);
      step(1);
      chk("R5 at expiry", fault_n, 0, pgood_n, 1);

      // R5: pulse one short, then restart
      idle(); step(LAT + 1);
      en_aux = 1; step(LAT);
      oc_slow = 1; step(T);
      oc_slow = 0; step(1);
      oc_slow = 1; step(T);
      oc_slow = 0; step(LAT + 2);
      chk("R5 short pulses", fault_n, 1, pgood_n, 0);

      // R8: latch held by either enable, released by both
      oc_fast = 1; en_main = 1; step(LAT);
      chk("R4 fast", fault_n, 0, pgood_n, 1);
      oc_fast = 0; step(LAT + 2);
      chk("R8 hold after trip gone", fault_n, 0, pgood_n, 1);
      en_main = 0; step(LAT + 2);
      chk("R8 hold on aux", fault_n, 0, pgood_n, 1);
      en_aux = 0; step(LAT - 1);
      chk("R8 not yet released", fault_n, 0, pgood_n, 1);
      step(1);
      chk("R8 released", fault_n, 1, pgood_n, 1);

      // R9: force-on clears latch and hides trips
      en_main = 1; ot_global = 1; step(LAT);
      chk("R7 global", fault_n, 0, pgood_n, 1);
      force_on_n = 0; step(LAT);
      chk("R9 force clears", fault_n, 1, pgood_n, 1);
      uv_12 = 1; oc_fast = 1; step(LAT + 1);
      chk("R9 trips ignored", fault_n, 1, pgood_n, 1);
      ot_global = 0; uv_12 = 0; oc_fast = 0; step(LAT);
      chk("R9 no pgood under force", fault_n, 1, pgood_n, 1);

      // R10: inhibit restores protection
      force_inhibit = 1; step(1);
      chk("R10 pgood returns", fault_n, 1, pgood_n, 0);
      uv_stby = 1; step(LAT);
      chk("R10 fault under inhibit", fault_n, 0, pgood_n, 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule